// File: doc/BRIEF.md
# Complementary-storage secure RAM controller

This block sits between a simple request/ready bus and a 256-byte register-array memory meant for volatile secrets. The memory is organised as 32 rows of 64 bits, written with per-byte enables and read a whole row at a time. Bus accesses may be bytes, half-words or words. While the block is enabled, a 6-bit address key and a 32-bit data key can scramble where and how values land in the array. A RAM-inverted status input lets a neighbouring remanence engine flip the stored polarity without software seeing any change.

In silent mode each bus value takes a full 64-bit row. The low half holds the transformed value and the high half holds its bitwise complement, so only 128 bytes are visible. Every silent read checks the pair and ends with a bus error if the two halves are not exact complements. Word-size accesses are suppressed in this mode. While disabled, the block passes accesses straight to the array with no transform of any kind.

Top module: `shield_ram_ctrl`

## Requirements
- R1: A request sampled with `req` high at a rising edge produces `ready` high for exactly one cycle, at the next edge. Without a request, `ready` stays low. After reset, `ready`, `err` and `rdata` are 0 and every array byte is 0.
- R2: `size` 0 is a byte on lane `addr[1:0]`, 1 is a half-word on lanes 0-1 (`addr[1]`=0) or lanes 2-3 (`addr[1]`=1), and 2 or 3 is a word on all four lanes. Lanes outside the access read as zero in `rdata`, and are never written.
- R3: With `enable` low, the word address w=`addr[7:2]` selects row w>>1, half w[0] (1 = upper 32 bits). Data is stored and returned unchanged, no complement check is made and `err` stays 0, whatever `silent`, `scr_en` and `ram_inv` are.
- R4: With `enable` and `scr_en` both high in normal mode, w=`addr[7:2]` XOR `key_addr` and the stored data is the bus data XOR `key_data`. A read applies the same transform, so data reads back unchanged.
- R5: With `enable` high, `ram_inv` high inverts every stored and returned bit. Data written and read under the same `ram_inv` value reads back unchanged.
- R6: With `enable` and `silent` high, `addr[7]` is ignored. The row is `addr[6:2]` XOR `key_addr[4:0]` (the key applies only when `scr_en` is high). The low half holds the transformed data and the high half holds its bitwise complement, on the same lanes.
- R7: With `enable` and `silent` high, a word-size write changes nothing in the array, and a word-size read returns 0 with `err` low.
- R8: On a silent-mode byte or half-word read, if any accessed lane of the low half XOR the same lane of the high half is not 8'hFF, `err` is 1 and `rdata` is 0.
- R9: Scrambling is applied only when `enable` and `scr_en` are both high. Setting `scr_en` alone while disabled has no effect.
- R10: `err` is raised only together with `ready`, and only for a read issued while `enable` and `silent` were high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one access per cycle it is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address |
| size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with ready |
| ready | output | 1 | Access completes |
| err | output | 1 | Bus error response |
| enable | input | 1 | Module enable |
| silent | input | 1 | Complementary-pair storage mode |
| scr_en | input | 1 | Scramble enable |
| ram_inv | input | 1 | RAM-inverted status |
| key_addr | input | 6 | Address scramble key |
| key_data | input | 32 | Data scramble key |

## Verification
The bench keeps a byte-level image of the physical array, so it can catch accesses made in one mode that land in the wrong place when read in another. A plain read issued after a scrambled write reveals whether the key really reached the array. A design that applied the key on only one side would return garbage on the scrambled round trip. A silent-mode word write is followed by half-word reads of the same row, so a design that let the word through would show changed data. The pair check is forced to fail by corrupting one high-half byte through a plain write. Reads of never-written silent rows must also fail, so a check that skipped lanes or compared the wrong halves would miss the error. The `addr[7]` alias and the effect of `ram_inv` being ignored while disabled are exercised directly.

// File: rtl/shield_ram_pkg.sv
`timescale 1ns/1ps
package shield_ram_pkg;
    localparam int LANES     = 4;
    localparam int BUS_W     = 8 * LANES;
    localparam int MEM_BYTES = 256;
    localparam int ROW_LANES = 2 * LANES;
    localparam int ROW_W     = 8 * ROW_LANES;
    localparam int ROWS      = MEM_BYTES / ROW_LANES;
    localparam int ROW_AW    = $clog2(ROWS);
    localparam int WORD_AW   = ROW_AW + 1;
    localparam int BYTE_AW   = $clog2(MEM_BYTES);
    localparam int LANE_AW   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } size_e;

    typedef struct packed {
        logic             valid;
        logic             rd;
        logic             silent;
        logic             drop;
        logic             upper;
        logic [LANES-1:0] lanes;
        logic [BUS_W-1:0] xform;
    } resp_ctl_t;

    function automatic logic [LANES-1:0] lane_sel(input logic [1:0] sz,
                                                  input logic [LANE_AW-1:0] lo);
        logic [LANES-1:0] m;
        case (size_e'(sz))
            SZ_BYTE: m = LANES'(1) << lo;
            SZ_HALF: m = LANES'(3) << {lo[LANE_AW-1], 1'b0};
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] m);
        logic [BUS_W-1:0] b;
        for (int i = 0; i < LANES; i++) b[8*i +: 8] = {8{m[i]}};
        return b;
    endfunction
endpackage

// File: rtl/shield_ram_front.sv
`timescale 1ns/1ps
module shield_ram_front
    import shield_ram_pkg::*;
(
    input  logic                 req,
    input  logic                 we,
    input  logic [BYTE_AW-1:0]   addr,
    input  logic [1:0]           size,
    input  logic [BUS_W-1:0]     wdata,
    input  logic                 enable,
    input  logic                 silent,
    input  logic                 scr_en,
    input  logic                 ram_inv,
    input  logic [WORD_AW-1:0]   key_addr,
    input  logic [BUS_W-1:0]     key_data,
    output logic [ROW_AW-1:0]    row,
    output logic [ROW_LANES-1:0] be,
    output logic [ROW_W-1:0]     wd,
    output resp_ctl_t            ctl
);
    logic                sil_on, scr_on, is_word, wr, upper;
    logic [WORD_AW-1:0]  akey, waddr;
    logic [LANES-1:0]    lanes;
    logic [BUS_W-1:0]    xform, stored;

    always_comb begin
        sil_on  = enable & silent;
        scr_on  = enable & scr_en;
        is_word = size[1];
        akey    = scr_on ? key_addr : '0;
        lanes   = lane_sel(size, addr[LANE_AW-1:0]);
        xform   = (scr_on ? key_data : '0) ^ {BUS_W{enable & ram_inv}};
        stored  = wdata ^ xform;
        wr      = req & we & ~(sil_on & is_word);
        if (sil_on) begin
            waddr = {1'b0, addr[BYTE_AW-2:LANE_AW] ^ akey[WORD_AW-2:0]};
            row   = waddr[ROW_AW-1:0];
            upper = 1'b0;
            wd    = {~stored, stored};
            be    = wr ? {lanes, lanes} : '0;
        end else begin
            waddr = addr[BYTE_AW-1:LANE_AW] ^ akey;
            row   = waddr[WORD_AW-1:1];
            upper = waddr[0];
            wd    = {stored, stored};
            be    = !wr ? '0 : (upper ? {lanes, {LANES{1'b0}}} : {{LANES{1'b0}}, lanes});
        end
        ctl.valid  = req;
        ctl.rd     = ~we;
        ctl.silent = sil_on;
        ctl.drop   = sil_on & is_word;
        ctl.upper  = upper;
        ctl.lanes  = lanes;
        ctl.xform  = xform;
    end
endmodule

// File: rtl/shield_ram_array.sv
`timescale 1ns/1ps
module shield_ram_array
    import shield_ram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  logic [ROW_AW-1:0]    row,
    input  logic [ROW_LANES-1:0] be,
    input  logic [ROW_W-1:0]     wd,
    output logic [ROW_W-1:0]     rd_q
);
    for (genvar b = 0; b < ROW_LANES; b++) begin : g_lane
        logic [7:0] cells [ROWS];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int r = 0; r < ROWS; r++) cells[r] <= '0;
                rd_q[8*b +: 8] <= '0;
            end else begin
                if (be[b]) cells[row] <= wd[8*b +: 8];
                if (rd_en) rd_q[8*b +: 8] <= cells[row];
            end
        end
    end
endmodule

// File: rtl/shield_ram_back.sv
`timescale 1ns/1ps
module shield_ram_back
    import shield_ram_pkg::*;
(
    input  resp_ctl_t        ctl,
    input  logic [ROW_W-1:0] rd_q,
    output logic [BUS_W-1:0] rdata,
    output logic             err
);
    logic [BUS_W-1:0] lo, hi, mask, raw;
    logic             bad;

    always_comb begin
        lo    = rd_q[BUS_W-1:0];
        hi    = rd_q[ROW_W-1:BUS_W];
        mask  = lane_bits(ctl.lanes);
        raw   = (!ctl.silent && ctl.upper) ? hi : lo;
        bad   = ctl.silent && (((lo ^ ~hi) & mask) != '0);
        rdata = '0;
        err   = 1'b0;
        if (ctl.valid && ctl.rd && !ctl.drop) begin
            if (bad) err = 1'b1;
            else     rdata = (raw ^ ctl.xform) & mask;
        end
    end
endmodule

// File: rtl/shield_ram_ctrl.sv
`timescale 1ns/1ps
module shield_ram_ctrl
    import shield_ram_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               we,
    input  logic [7:0]         addr,
    input  logic [1:0]         size,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               ready,
    output logic               err,
    input  logic               enable,
    input  logic               silent,
    input  logic               scr_en,
    input  logic               ram_inv,
    input  logic [5:0]         key_addr,
    input  logic [31:0]        key_data
);
    logic [ROW_AW-1:0]    ram_row;
    logic [ROW_LANES-1:0] ram_be;
    logic [ROW_W-1:0]     ram_wd, ram_rd;
    resp_ctl_t            ctl_n, ctl_q;

    shield_ram_front u_front (
        .req(req), .we(we), .addr(addr), .size(size), .wdata(wdata),
        .enable(enable), .silent(silent), .scr_en(scr_en), .ram_inv(ram_inv),
        .key_addr(key_addr), .key_data(key_data),
        .row(ram_row), .be(ram_be), .wd(ram_wd), .ctl(ctl_n)
    );

    shield_ram_array u_array (
        .clk(clk), .rst(rst), .rd_en(req), .row(ram_row),
        .be(ram_be), .wd(ram_wd), .rd_q(ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_n;
    end

    shield_ram_back u_back (
        .ctl(ctl_q), .rd_q(ram_rd), .rdata(rdata), .err(err)
    );

    assign ready = ctl_q.valid;
endmodule

// File: rtl/shield_ram_chk.sv
`timescale 1ns/1ps
module shield_ram_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic        we,
    input logic [1:0]  size,
    input logic        enable,
    input logic        silent,
    input logic        ready,
    input logic        err,
    input logic [31:0] rdata,
    input logic [7:0]  ram_be,
    input logic [63:0] ram_wd
);
    a_r1_ready_follows: assert property (@(posedge clk) disable iff (rst)
        req |=> ready);
    a_r1_ready_idle: assert property (@(posedge clk) disable iff (rst)
        !req |=> !ready);
    a_r10_err_with_ready: assert property (@(posedge clk) disable iff (rst)
        err |-> ready);
    a_r10_err_silent_read: assert property (@(posedge clk) disable iff (rst)
        (req && !(enable && silent && !we)) |=> !err);
    a_r7_word_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (req && we && enable && silent && size[1]) |-> (ram_be == 8'h00));
    a_r7_word_read_zero: assert property (@(posedge clk) disable iff (rst)
        (req && !we && enable && silent && size[1]) |=> (rdata == 32'h0 && !err));
    a_r6_pair_complement: assert property (@(posedge clk) disable iff (rst)
        (enable && silent && ram_be != 8'h00) |->
            (ram_be[7:4] == ram_be[3:0] && ram_wd[63:32] == ~ram_wd[31:0]));
    a_r3_plain_no_err: assert property (@(posedge clk) disable iff (rst)
        (req && !enable) |=> !err);
endmodule

bind shield_ram_ctrl shield_ram_chk u_chk (
    .clk(clk), .rst(rst), .req(req), .we(we), .size(size),
    .enable(enable), .silent(silent), .ready(ready), .err(err),
    .rdata(rdata), .ram_be(ram_be), .ram_wd(ram_wd)
);

// File: tb/sim_shield_ram_ctrl.sv
`timescale 1ns/1ps
module sim_shield_ram_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready, err;
    logic        en = 1'b0, sil = 1'b0, scr = 1'b0, inv = 1'b0;
    logic [5:0]  kaddr = '0;
    logic [31:0] kdata = '0;

    logic [7:0]  phys [256];
    int          total = 0, bad = 0;

    always #2.5 clk = ~clk;

    shield_ram_ctrl u0 (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .rdata(rdata), .ready(ready), .err(err),
        .enable(en), .silent(sil), .scr_en(scr), .ram_inv(inv),
        .key_addr(kaddr), .key_data(kdata)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [3:0] lanes_of(input logic [1:0] sz, input logic [7:0] a);
        if (sz == 2'd0) return 4'b0001 << a[1:0];
        if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    task automatic access(input string rq, input bit w, input logic [7:0] a,
                          input logic [1:0] sz, input logic [31:0] d);
        logic [3:0]  ln;
        logic [31:0] xf, er;
        logic [7:0]  lo;
        logic        ee;
        int          base;
        @(negedge clk);
        chk("R1 idle", {31'b0, ready}, 32'd0);
        ln = lanes_of(sz, a);
        xf = en ? ((scr ? kdata : 32'h0) ^ (inv ? 32'hFFFF_FFFF : 32'h0)) : 32'h0;
        er = '0;
        ee = 1'b0;
        if (en && sil) begin
            if (!sz[1]) begin
                base = int'(a[6:2] ^ (scr ? kaddr[4:0] : 5'd0)) * 8;
                for (int l = 0; l < 4; l++) if (ln[l]) begin
                    if (w) begin
                        lo = d[8*l +: 8] ^ xf[8*l +: 8];
                        phys[base + l]     = lo;
                        phys[base + 4 + l] = ~lo;
                    end else begin
                        if ((phys[base + l] ^ phys[base + 4 + l]) != 8'hFF) ee = 1'b1;
                        er[8*l +: 8] = phys[base + l] ^ xf[8*l +: 8];
                    end
                end
                if (ee) er = '0;
            end
        end else begin
            base = int'(a[7:2] ^ ((en && scr) ? kaddr : 6'd0)) * 4;
            for (int l = 0; l < 4; l++) if (ln[l]) begin
                if (w) phys[base + l] = d[8*l +: 8] ^ xf[8*l +: 8];
                else   er[8*l +: 8] = phys[base + l] ^ xf[8*l +: 8];
            end
        end
        if (w) er = '0;
        req = 1'b1; we = w; addr = a; size = sz; wdata = d;
        @(negedge clk);
        req = 1'b0;
        chk({rq, " ready"}, {31'b0, ready}, 32'd1);
        chk({rq, " err"}, {31'b0, err}, {31'b0, ee});
        chk({rq, " rdata"}, rdata, er);
    endtask

    task automatic rand_run(input string rq, input int n, input bit words);
        for (int i = 0; i < n; i++) begin
            logic [1:0] sz;
            sz = words ? 2'($urandom % 4) : 2'($urandom % 2);
            access(rq, 1'($urandom % 2), 8'($urandom), sz, $urandom);
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) phys[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset ready", {31'b0, ready}, 32'd0);
        chk("R1 reset err", {31'b0, err}, 32'd0);
        chk("R1 reset rdata", rdata, 32'd0);

        // R3: plain path, config inputs have no effect while disabled
        sil = 1'b1; scr = 1'b1; inv = 1'b1; kaddr = 6'h2B; kdata = 32'hA5C3_1E77;
        access("R3", 1'b1, 8'h10, 2'd2, 32'h1122_3344);
        access("R3", 1'b0, 8'h10, 2'd2, 32'h0);
        access("R2", 1'b1, 8'h13, 2'd0, 32'h0000_0000);
        access("R2", 1'b0, 8'h12, 2'd1, 32'h0);
        access("R9", 1'b0, 8'h10, 2'd0, 32'h0);
        rand_run("R3", 30, 1'b1);

        // R4: enabled, normal mode, with and without scrambling
        en = 1'b1; sil = 1'b0; inv = 1'b0; scr = 1'b0;
        rand_run("R9", 20, 1'b1);
        scr = 1'b1;
        access("R4", 1'b1, 8'h20, 2'd2, 32'hDEAD_BEEF);
        access("R4", 1'b0, 8'h20, 2'd2, 32'h0);
        rand_run("R4", 30, 1'b1);
        en = 1'b0;
        access("R9", 1'b0, 8'h20 ^ 8'(6'h2B << 2), 2'd2, 32'h0);
        rand_run("R9", 20, 1'b0);

        // R5: polarity flip
        en = 1'b1; inv = 1'b1;
        access("R5", 1'b1, 8'h44, 2'd1, 32'h0000_5A0F);
        access("R5", 1'b0, 8'h44, 2'd1, 32'h0);
        rand_run("R5", 30, 1'b1);
        inv = 1'b0;
        access("R5", 1'b0, 8'h44, 2'd1, 32'h0);

        // R6..R8: silent mode
        sil = 1'b1;
        access("R8", 1'b0, 8'h08, 2'd1, 32'h0);
        access("R6", 1'b1, 8'h04, 2'd1, 32'h0000_C3A1);
        access("R6", 1'b0, 8'h84, 2'd1, 32'h0);
        access("R7", 1'b1, 8'h04, 2'd2, 32'hFFFF_FFFF);
        access("R7", 1'b0, 8'h04, 2'd1, 32'h0);
        access("R7", 1'b0, 8'h04, 2'd2, 32'h0);
        access("R10", 1'b1, 8'h06, 2'd1, 32'h0000_7E11);
        access("R6", 1'b0, 8'h06, 2'd0, 32'h0);
        rand_run("R6", 60, 1'b1);
        // corrupt high half of the row behind bus address 0x04 (row 1^0x0B = 10)
        en = 1'b0;
        access("R8", 1'b1, 8'h54, 2'd0, 32'h0000_0000);
        access("R8", 1'b1, 8'h50, 2'd0, 32'h0000_0000);
        en = 1'b1;
        access("R8", 1'b0, 8'h04, 2'd0, 32'h0);
        access("R8", 1'b0, 8'h05, 2'd0, 32'h0);
        en = 1'b0;
        access("R10", 1'b0, 8'h54, 2'd0, 32'h0);

        @(negedge clk);
        chk("R1 idle", {31'b0, ready}, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule